// File: doc/BRIEF.md
# Strobed Overvoltage Fault Filter

This block decides whether an output overvoltage is real before it stops the converter. A comparator outside the block watches the voltage reflected onto the auxiliary winding and gives one bit. That bit only means something while the power switch is off, and even then only after the ringing that follows turn-off has died away. The block therefore waits a fixed number of clocks after each turn-off. It then looks at the comparator during a short window of clocks and forms a single pass or fail result for that oscillator cycle.

At each oscillator cycle start, the result of the cycle that just ended is judged. A cycle whose window was fully over the threshold adds one to a saturating count. Any other cycle, including one whose off-time ended before its window completed, clears the count. When the count reaches the limit (four by default), the fault output rises and stays high until the restart sequencer clears it. All pins are single-bit control or status levels and pulses. There is no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `ovp_strobe_filter`

## Requirements
- R1: During and right after reset, `trip_count_o` is 0 and `fault_o` is 0.
- R2: The clock edge that captures an accepted `sw_off_i` pulse is edge 0. The comparator is examined on edges STROBE_DLY+1 through STROBE_DLY+WIN_LEN, and on no other edge. The cycle counts as tripped only if `cmp_hi_i` is 1 on every one of those edges. Comparator activity outside the window has no effect.
- R3: Only the first `sw_off_i` pulse after a cycle start is accepted. Any later turn-off pulse in the same oscillator cycle is ignored, even if it would produce a tripped window.
- R4: If the ending cycle was tripped, a `cyc_start_i` pulse adds one to `trip_count_o`, saturating at TRIP_LIMIT. The new value is visible after that edge.
- R5: If the ending cycle was not tripped, a `cyc_start_i` pulse sets `trip_count_o` to 0. This includes a cycle whose off-time ended (next `cyc_start_i`) before the window's last edge.
- R6: `fault_o` rises on the same edge on which `trip_count_o` reaches TRIP_LIMIT (4 consecutive tripped cycles by default).
- R7: Once set, `fault_o` stays 1 and `trip_count_o` stays frozen. Only `fault_clr_i` changes them, and it sets both to 0.
- R8: A `sw_off_i` pulse in the same clock as `cyc_start_i` is ignored. `fault_clr_i` takes priority over a `cyc_start_i` in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (50 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start_i | input | 1 | One-clock pulse at each oscillator cycle start; also ends the off-time |
| sw_off_i | input | 1 | One-clock pulse when the power switch turns off |
| cmp_hi_i | input | 1 | Comparator bit, 1 when the auxiliary voltage is above threshold |
| fault_clr_i | input | 1 | One-clock clear from the restart sequencer |
| fault_o | output | 1 | Latched overvoltage fault |
| trip_count_o | output | CNT_W | Consecutive tripped-cycle count |

## Verification
On every cycle, the embedded properties check these points:
- the count never passes its limit;
- a non-tripped cycle start zeroes the count;
- a tripped one adds exactly one;
- the fault only rises together with a full count and holds until cleared;
- a trip result only appears straight after a window edge with the comparator high;
- once a turn-off has been taken, further ones are ignored until the next cycle start.

Only the bench scenarios can show the exact window placement against ringing and the edges just before and after the window. The same holds for a late turn-off whose window is cut short, a second turn-off in the same cycle, and the same-clock orderings of turn-off, cycle start and clear.

// File: rtl/ovp_filt_pkg.sv
package ovp_filt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DELAY  = 2'd1,
    ST_WINDOW = 2'd2,
    ST_DONE   = 2'd3
  } strobe_st_e;

  function automatic int unsigned bits_for(input int unsigned value);
    int unsigned b;
    b = 1;
    while ((1 << b) <= value) b++;
    return b;
  endfunction

endpackage

// File: rtl/ovp_strobe_sampler.sv
module ovp_strobe_sampler
  import ovp_filt_pkg::*;
#(
  parameter int unsigned STROBE_DLY = 110,
  parameter int unsigned WIN_LEN    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start_i,
  input  logic sw_off_i,
  input  logic cmp_hi_i,
  output logic trip_o
);

  localparam int unsigned TMR_MAX = (STROBE_DLY > WIN_LEN) ? STROBE_DLY : WIN_LEN;
  localparam int unsigned TMR_W   = bits_for(TMR_MAX);
  localparam logic [TMR_W-1:0] DLY_END = TMR_W'(STROBE_DLY - 1);
  localparam logic [TMR_W-1:0] WIN_END = TMR_W'(WIN_LEN - 1);

  strobe_st_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic             win_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      win_ok_q <= 1'b0;
      trip_o   <= 1'b0;
    end else if (cyc_start_i) begin
      // a new oscillator cycle ends the off-time and drops any pending sample
      state_q  <= ST_IDLE;
      tmr_q    <= '0;
      win_ok_q <= 1'b0;
      trip_o   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (sw_off_i) begin
            state_q <= ST_DELAY;
            tmr_q   <= '0;
          end
        end
        ST_DELAY: begin
          if (tmr_q == DLY_END) begin
            state_q  <= ST_WINDOW;
            tmr_q    <= '0;
            win_ok_q <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_WINDOW: begin
          if (!cmp_hi_i) win_ok_q <= 1'b0;
          if (tmr_q == WIN_END) begin
            state_q <= ST_DONE;
            trip_o  <= win_ok_q & cmp_hi_i;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          // sample already taken this cycle: further turn-offs ignored
          state_q <= ST_DONE;
        end
      endcase
    end
  end

  // R5: a cycle start always discards the previous result
  assert_trip_cleared_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_i |=> !trip_o);

  // R2: a trip result is only formed on a window edge with the comparator high
  assert_trip_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_o) |-> ($past(state_q) == ST_WINDOW) && $past(cmp_hi_i));

  // R3: once the sample is taken, nothing but a cycle start leaves that state
  assert_one_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) && !cyc_start_i |=> (state_q == ST_DONE));

  // R8: a turn-off together with a cycle start does not arm the delay
  assert_off_at_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_i && sw_off_i |=> (state_q == ST_IDLE));

endmodule

// File: rtl/ovp_trip_counter.sv
module ovp_trip_counter #(
  parameter int unsigned TRIP_LIMIT = 4,
  parameter int unsigned CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start_i,
  input  logic             trip_i,
  input  logic             fault_clr_i,
  output logic             fault_o,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(TRIP_LIMIT);

  logic [CNT_W-1:0] next_cnt;

  always_comb begin
    next_cnt = (count_o == LIMIT_V) ? count_o : count_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      fault_o <= 1'b0;
    end else if (fault_clr_i) begin
      count_o <= '0;
      fault_o <= 1'b0;
    end else if (cyc_start_i && !fault_o) begin
      if (trip_i) begin
        count_o <= next_cnt;
        if (next_cnt == LIMIT_V) fault_o <= 1'b1;
      end else begin
        count_o <= '0;
      end
    end
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count_o <= LIMIT_V);

  assert_fault_with_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_o) |-> (count_o == LIMIT_V));

  assert_no_trip_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_i && !trip_i && !fault_o && !fault_clr_i |=> (count_o == '0));

  assert_trip_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start_i && trip_i && !fault_o && !fault_clr_i && (count_o < LIMIT_V)
      |=> (count_o == $past(count_o) + 1'b1));

  assert_fault_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o && !fault_clr_i |=> fault_o && $stable(count_o));

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fault_clr_i |=> !fault_o && (count_o == '0));

endmodule

// File: rtl/ovp_strobe_filter.sv
module ovp_strobe_filter
  import ovp_filt_pkg::*;
#(
  parameter int unsigned STROBE_DLY = 110,
  parameter int unsigned WIN_LEN    = 4,
  parameter int unsigned TRIP_LIMIT = 4,
  localparam int unsigned CNT_W     = bits_for(TRIP_LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start_i,
  input  logic             sw_off_i,
  input  logic             cmp_hi_i,
  input  logic             fault_clr_i,
  output logic             fault_o,
  output logic [CNT_W-1:0] trip_count_o
);

  logic cycle_trip;

  ovp_strobe_sampler #(
    .STROBE_DLY (STROBE_DLY),
    .WIN_LEN    (WIN_LEN)
  ) u_sampler (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .sw_off_i    (sw_off_i),
    .cmp_hi_i    (cmp_hi_i),
    .trip_o      (cycle_trip)
  );

  ovp_trip_counter #(
    .TRIP_LIMIT (TRIP_LIMIT),
    .CNT_W      (CNT_W)
  ) u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .cyc_start_i (cyc_start_i),
    .trip_i      (cycle_trip),
    .fault_clr_i (fault_clr_i),
    .fault_o     (fault_o),
    .count_o     (trip_count_o)
  );

  // R1: outputs come out of reset cleared
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (trip_count_o == '0) && !fault_o);

endmodule

// File: tb/ovp_strobe_filter_tb.sv
module ovp_strobe_filter_tb;

  localparam int DLY = 110;
  localparam int WIN = 4;
  localparam int LIM = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc = 1'b0, sw = 1'b0, cmp = 1'b0, clr = 1'b0;
  logic       fault;
  logic [2:0] cnt;

  int checks = 0;
  int failures = 0;
  int ticks = 0;

  // behavioural reference
  int  m_cnt = 0, m_age = -1;
  bit  m_flt = 0, m_busy = 0, m_ok = 0, m_trip = 0;

  ovp_strobe_filter #(.STROBE_DLY(DLY), .WIN_LEN(WIN), .TRIP_LIMIT(LIM)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start_i(cyc), .sw_off_i(sw),
    .cmp_hi_i(cmp), .fault_clr_i(clr), .fault_o(fault), .trip_count_o(cnt));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_flt = 0; m_busy = 0; m_age = -1; m_ok = 0; m_trip = 0;
    end else begin
      if (clr) begin
        m_cnt = 0; m_flt = 0;
      end else if (cyc && !m_flt) begin
        if (m_trip) begin
          if (m_cnt < LIM) m_cnt = m_cnt + 1;
          if (m_cnt == LIM) m_flt = 1;
        end else m_cnt = 0;
      end
      if (cyc) begin
        m_busy = 0; m_age = -1; m_trip = 0;
      end else if (!m_busy) begin
        if (sw) begin m_busy = 1; m_age = 0; m_ok = 1; end
      end else begin
        m_age = m_age + 1;
        if (m_age >= DLY + 1 && m_age <= DLY + WIN) begin
          if (!cmp) m_ok = 0;
          if (m_age == DLY + WIN) m_trip = m_ok;
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    ticks++;
    if (rst_n) begin
      chk("R4/R5 model count", int'(cnt), m_cnt);
      chk("R6/R7 model fault", int'(fault), int'(m_flt));
    end
  end

  function automatic logic cmp_val(input int mode, input int i, input int t);
    case (mode)
      1: return 1'b1;
      2: return (t >= 0 && t <= 60);
      3: return (t != DLY + 2);
      4: return (t >= DLY + 1 && t <= DLY + WIN);
      5: return (t >= DLY + 1 && t <= DLY + WIN - 1);
      6: return (i >= 140);
      default: return 1'b0;
    endcase
  endfunction

  task automatic kick(input bit with_off, input bit with_clr);
    @(negedge clk);
    cyc = 1'b1; sw = with_off; clr = with_clr;
    @(negedge clk);
    cyc = 1'b0; sw = 1'b0; clr = 1'b0;
  endtask

  task automatic osc(input int off_at, input int off2, input int mode, input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      sw  = (i == off_at) || (i == off2);
      cmp = cmp_val(mode, i, i - off_at);
    end
    @(negedge clk);
    sw = 1'b0; cmp = 1'b0;
  endtask

  task automatic tripped_cycles(input int n);
    for (int k = 0; k < n; k++) begin
      osc(20, -1, 1, 200);
      kick(1'b0, 1'b0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 count in reset", int'(cnt), 0);
    chk("R1 fault in reset", int'(fault), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count after reset", int'(cnt), 0);
    kick(1'b0, 1'b0);

    tripped_cycles(1);
    chk("R4 one tripped cycle", int'(cnt), 1);
    osc(20, -1, 2, 200); kick(1'b0, 1'b0);
    chk("R2 ringing only ignored", int'(cnt), 0);
    tripped_cycles(3);
    chk("R4 three tripped cycles", int'(cnt), 3);
    chk("R6 no fault below limit", int'(fault), 0);
    osc(20, -1, 3, 200); kick(1'b0, 1'b0);
    chk("R2 glitch in window", int'(cnt), 0);

    osc(20, -1, 4, 200); kick(1'b0, 1'b0);
    chk("R2 exact window high", int'(cnt), 1);
    osc(20, -1, 5, 200); kick(1'b0, 1'b0);
    chk("R2 low on last window edge", int'(cnt), 0);

    tripped_cycles(4);
    chk("R6 fault at limit", int'(fault), 1);
    chk("R6 count at limit", int'(cnt), 4);
    osc(20, -1, 0, 200); kick(1'b0, 1'b0);
    chk("R7 fault held", int'(fault), 1);
    chk("R7 count frozen", int'(cnt), 4);
    kick(1'b0, 1'b1);
    chk("R7 clear fault", int'(fault), 0);
    chk("R7 clear count", int'(cnt), 0);

    tripped_cycles(2);
    osc(150, -1, 1, 200); kick(1'b0, 1'b0);
    chk("R5 window cut by cycle start", int'(cnt), 0);

    tripped_cycles(2);
    osc(20, 140, 6, 260); kick(1'b0, 1'b0);
    chk("R3 second turn-off ignored", int'(cnt), 0);

    tripped_cycles(1);
    kick(1'b1, 1'b0);
    osc(-1, -1, 1, 200); kick(1'b0, 1'b0);
    chk("R8 turn-off at cycle start ignored", int'(cnt), 0);

    tripped_cycles(5);
    chk("R6 fault again", int'(fault), 1);
    osc(20, -1, 1, 200); kick(1'b0, 1'b1);
    chk("R8 clear beats cycle start fault", int'(fault), 0);
    chk("R8 clear beats cycle start count", int'(cnt), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (ticks > 150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", ticks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule